// File: doc/BRIEF.md
# Trim Code Window-Centering Sequencer

This block trims an adjustable analog quantity, such as an oscillator's free-running frequency or a filter corner, without help from software. After a start pulse it sets the trim code to zero and raises it one step at a time up to the top of the selected width. After each step it waits a programmable number of clock cycles for the analog side to settle, then samples one or two status flags. From those flags it records the first code that passes and the last code of that same unbroken passing run. When the sweep is over it programs the code halfway between the two.

Two pass conditions are built in. A single "in range" flag serves filter-style trims. Those trims run with a test-mode output raised so that the measured circuit reports its status. A pair of flags serves oscillator-style trims, where a code passes only when the first flag is low and the second is high. If no code passes, the sequencer restores a default code and raises an error together with done.

Top module: `trim_center_seq`

## Requirements
- R1: After reset, trim_code equals the narrow default (8), and busy, done, error and test_mode are all 0.
- R2: A start pulse accepted while idle sets trim_code to 0 on the next edge. Each code is held for settle_len+1 cycles and then increased by one, up to 15 when wide_sel=0 (upper two bits stay 0) or up to 63 when wide_sel=1. done rises one cycle after the last code's flags are sampled, so the run lasts (max+1)*(settle_len+1)+1 cycles.
- R3: With pair_mode=0, a code passes exactly when flag_a=1, and flag_b has no effect.
- R4: With pair_mode=1, a code passes exactly when flag_a=0 and flag_b=1. Both flags high, or both flags low, is a fail.
- R5: When some code passes, the final trim_code is floor((first+last)/2), where first and last bound the first contiguous passing run. The code then stays unchanged while idle.
- R6: Passing codes that appear after the first run has ended do not move the result.
- R7: When no code passes, trim_code returns to the default for the selected width (8 narrow, 31 wide), and error=1 is raised together with done=1. error is 0 after a run that found a pass.
- R8: busy is 1 from the edge that accepts start until the edge that raises done. done and error hold until the next accepted start, which clears both.
- R9: A start pulse while busy is ignored: the sweep, its timing and its result are unchanged.
- R10: test_mode is 1 during a sweep with pair_mode=0, and 0 during a pair-mode sweep and whenever idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request to begin a sweep |
| wide_sel | input | 1 | 0: 4-bit sweep, 1: 6-bit sweep (captured at start) |
| pair_mode | input | 1 | 0: single OK flag, 1: two-flag condition (captured at start) |
| flag_a | input | 1 | OK flag (single mode) or first status flag (pair mode) |
| flag_b | input | 1 | Second status flag (pair mode only) |
| settle_len | input | SETTLE_W | Extra wait cycles after each code before sampling |
| trim_code | output | WIDE_W | Trim code driven to the analog circuit |
| test_mode | output | 1 | Raised during single-flag sweeps |
| busy | output | 1 | Sweep in progress |
| done | output | 1 | Sweep complete; holds until next start |
| error | output | 1 | No passing code found; valid with done |

## Verification
The sweep runs against a bench model of the analog circuit. Each trial places one or two passing windows at chosen codes, and the flags follow trim_code. Directed cases cover a window at code 0, a window ending at the top code, a one-code window, two separated windows (only the first may count), and an empty window in both widths. Together they separate correct midpoint rounding, run-end detection and fallback to the default. In single mode the bench drives flag_b at random, which shows that flag_b is ignored. In pair mode, codes below the window drive both flags high and codes above drive both low, so a design that checks only one of the two flags picks the wrong window. Random trials vary width, mode, settle time and window placement, and some insert a stray start mid-sweep. Every trial checks the exact code held in each cycle and the total run length.

// File: rtl/trim_seq_pkg.sv
package trim_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETTLE = 2'd1,
    ST_FINISH = 2'd2
  } seq_state_e;
endpackage

// File: rtl/trim_pass_eval.sv
module trim_pass_eval (
  input  logic pair_mode,
  input  logic flag_a,
  input  logic flag_b,
  output logic pass
);
  always_comb begin
    if (pair_mode) pass = ~flag_a & flag_b;
    else           pass = flag_a;
  end
endmodule

// File: rtl/trim_settle_timer.sv
module trim_settle_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (load) begin
      cnt_en = 1'b1;
      cnt_d  = load_val;
    end else if (cnt_q != '0) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/trim_window_track.sv
module trim_window_track #(
  parameter int CODE_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              sample,
  input  logic              pass,
  input  logic [CODE_W-1:0] code,
  output logic              found,
  output logic [CODE_W-1:0] first,
  output logic [CODE_W-1:0] last
);
  logic              found_q, found_d;
  logic              closed_q, closed_d;
  logic [CODE_W-1:0] first_q, first_d;
  logic [CODE_W-1:0] last_q, last_d;
  logic              upd_en;

  always_comb begin
    found_d  = found_q;
    closed_d = closed_q;
    first_d  = first_q;
    last_d   = last_q;
    upd_en   = clear | sample;
    if (clear) begin
      found_d  = 1'b0;
      closed_d = 1'b0;
      first_d  = '0;
      last_d   = '0;
    end else if (sample) begin
      if (pass && !found_q) begin
        found_d = 1'b1;
        first_d = code;
        last_d  = code;
      end else if (pass && !closed_q) begin
        last_d = code;
      end else if (!pass && found_q) begin
        closed_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      found_q  <= 1'b0;
      closed_q <= 1'b0;
      first_q  <= '0;
      last_q   <= '0;
    end else if (upd_en) begin
      found_q  <= found_d;
      closed_q <= closed_d;
      first_q  <= first_d;
      last_q   <= last_d;
    end
  end

  assign found = found_q;
  assign first = first_q;
  assign last  = last_q;
endmodule

// File: rtl/trim_center_seq.sv
module trim_center_seq
  import trim_seq_pkg::*;
#(
  parameter int SETTLE_W   = 8,
  parameter int NARROW_W   = 4,
  parameter int WIDE_W     = 6,
  parameter int DEF_NARROW = 8,
  parameter int DEF_WIDE   = 31
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic                wide_sel,
  input  logic                pair_mode,
  input  logic                flag_a,
  input  logic                flag_b,
  input  logic [SETTLE_W-1:0] settle_len,
  output logic [WIDE_W-1:0]   trim_code,
  output logic                test_mode,
  output logic                busy,
  output logic                done,
  output logic                error
);
  localparam logic [WIDE_W-1:0] NARROW_MAX = WIDE_W'((1 << NARROW_W) - 1);
  localparam logic [WIDE_W-1:0] WIDE_MAX   = WIDE_W'((1 << WIDE_W) - 1);
  localparam logic [WIDE_W-1:0] DEF_N_CODE = WIDE_W'(DEF_NARROW);
  localparam logic [WIDE_W-1:0] DEF_W_CODE = WIDE_W'(DEF_WIDE);

  seq_state_e        state_q, state_d;
  logic [WIDE_W-1:0] code_q, code_d;
  logic              wide_q, wide_d;
  logic              pair_q, pair_d;
  logic              done_q, done_d;
  logic              err_q, err_d;
  logic              reg_en;

  logic              pass;
  logic              expired;
  logic              tmr_load;
  logic              trk_clear;
  logic              trk_sample;
  logic              found;
  logic [WIDE_W-1:0] first_code;
  logic [WIDE_W-1:0] last_code;
  logic [WIDE_W:0]   span_sum;
  logic [WIDE_W-1:0] mid_code;
  logic [WIDE_W-1:0] max_code;
  logic              at_top;

  trim_pass_eval u_pass (
    .pair_mode (pair_q),
    .flag_a    (flag_a),
    .flag_b    (flag_b),
    .pass      (pass)
  );

  trim_settle_timer #(.CNT_W(SETTLE_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (settle_len),
    .expired  (expired)
  );

  trim_window_track #(.CODE_W(WIDE_W)) u_track (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (trk_clear),
    .sample (trk_sample),
    .pass   (pass),
    .code   (code_q),
    .found  (found),
    .first  (first_code),
    .last   (last_code)
  );

  assign max_code = wide_q ? WIDE_MAX : NARROW_MAX;
  assign at_top   = (code_q == max_code);
  assign span_sum = {1'b0, first_code} + {1'b0, last_code};
  assign mid_code = span_sum[WIDE_W:1];

  always_comb begin
    state_d    = state_q;
    code_d     = code_q;
    wide_d     = wide_q;
    pair_d     = pair_q;
    done_d     = done_q;
    err_d      = err_q;
    reg_en     = 1'b0;
    tmr_load   = 1'b0;
    trk_clear  = 1'b0;
    trk_sample = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          reg_en    = 1'b1;
          tmr_load  = 1'b1;
          trk_clear = 1'b1;
          state_d   = ST_SETTLE;
          code_d    = '0;
          wide_d    = wide_sel;
          pair_d    = pair_mode;
          done_d    = 1'b0;
          err_d     = 1'b0;
        end
      end
      ST_SETTLE: begin
        if (expired) begin
          reg_en     = 1'b1;
          trk_sample = 1'b1;
          if (at_top) begin
            state_d = ST_FINISH;
          end else begin
            tmr_load = 1'b1;
            code_d   = code_q + 1'b1;
          end
        end
      end
      ST_FINISH: begin
        reg_en  = 1'b1;
        state_d = ST_IDLE;
        done_d  = 1'b1;
        if (found) begin
          code_d = mid_code;
          err_d  = 1'b0;
        end else begin
          code_d = wide_q ? DEF_W_CODE : DEF_N_CODE;
          err_d  = 1'b1;
        end
      end
      default: begin
        reg_en  = 1'b1;
        state_d = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      code_q  <= DEF_N_CODE;
      wide_q  <= 1'b0;
      pair_q  <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else if (reg_en) begin
      state_q <= state_d;
      code_q  <= code_d;
      wide_q  <= wide_d;
      pair_q  <= pair_d;
      done_q  <= done_d;
      err_q   <= err_d;
    end
  end

  assign trim_code = code_q;
  assign busy      = (state_q != ST_IDLE);
  assign test_mode = busy & ~pair_q;
  assign done      = done_q;
  assign error     = err_q;
endmodule

// File: rtl/trim_center_seq_chk.sv
module trim_center_seq_chk #(
  parameter int WIDE_W     = 6,
  parameter int NARROW_W   = 4,
  parameter int DEF_NARROW = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic              error,
  input logic [WIDE_W-1:0] trim_code,
  input logic              wide_q
);
  localparam logic [WIDE_W-1:0] NMAX = WIDE_W'((1 << NARROW_W) - 1);
  localparam logic [WIDE_W-1:0] NDEF = WIDE_W'(DEF_NARROW);

  AST_NARROW_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !wide_q) |-> (trim_code <= NMAX)); // R2

  AST_STEP_UP: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && (trim_code != $past(trim_code)))
      |-> (trim_code == $past(trim_code) + 1'b1)); // R2

  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && $past(!busy)) |-> $stable(trim_code)); // R5

  AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    error |-> done); // R7

  AST_ERR_DEFAULT: assert property (@(posedge clk) disable iff (!rst_n)
    (error && !wide_q) |-> (trim_code == NDEF)); // R7

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R8

  AST_CLEAR_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (!done && !error)); // R8
endmodule

bind trim_center_seq trim_center_seq_chk #(
  .WIDE_W     (WIDE_W),
  .NARROW_W   (NARROW_W),
  .DEF_NARROW (DEF_NARROW)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .busy      (busy),
  .done      (done),
  .error     (error),
  .trim_code (trim_code),
  .wide_q    (wide_q)
);

// File: tb/tb_trim_center_seq.sv
module tb_trim_center_seq;
  logic       clk;
  logic       rst_n;
  logic       start;
  logic       wide_sel;
  logic       pair_mode;
  logic       flag_a;
  logic       flag_b;
  logic [7:0] settle_len;
  logic [5:0] trim_code;
  logic       test_mode;
  logic       busy;
  logic       done;
  logic       error;

  int n_checks = 0;
  int n_fails  = 0;

  int  w_lo1, w_hi1, w_lo2, w_hi2;
  bit  cur_pair;

  trim_center_seq dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .wide_sel   (wide_sel),
    .pair_mode  (pair_mode),
    .flag_a     (flag_a),
    .flag_b     (flag_b),
    .settle_len (settle_len),
    .trim_code  (trim_code),
    .test_mode  (test_mode),
    .busy       (busy),
    .done       (done),
    .error      (error)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic bit in_win(int c);
    return ((c >= w_lo1) && (c <= w_hi1)) || ((c >= w_lo2) && (c <= w_hi2));
  endfunction

  // analog circuit model: flags follow the applied code
  always @(negedge clk) begin
    int c;
    c = int'(trim_code);
    if (!cur_pair) begin
      flag_a = in_win(c);
      flag_b = 1'($urandom % 2);         // R3: must not matter
    end else if (in_win(c)) begin
      flag_a = 1'b0;
      flag_b = 1'b1;
    end else if (c < w_lo1) begin
      flag_a = 1'b1;
      flag_b = 1'b1;                     // R4: b alone is not a pass
    end else begin
      flag_a = 1'b0;
      flag_b = 1'b0;                     // R4: a low alone is not a pass
    end
  end

  function automatic int exp_result(int top, int def_code, output bit none);
    int f, l;
    bit seen, ended;
    seen = 0; ended = 0; f = 0; l = 0;
    for (int c = 0; c <= top; c++) begin
      if (in_win(c) && !seen) begin seen = 1; f = c; l = c; end
      else if (in_win(c) && !ended) l = c;
      else if (!in_win(c) && seen) ended = 1;
    end
    none = !seen;
    return seen ? (f + l) / 2 : def_code;
  endfunction

  task automatic check(bit ok, string req, string what, int act, int expv);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic run(bit wide, bit pair, int s, int lo1, int hi1,
                     int lo2, int hi2, bit inject);
    int  top, def_code, cyc, expc, res, bad_code, bad_tm, exp_len;
    bit  none;
    top      = wide ? 63 : 15;
    def_code = wide ? 31 : 8;
    w_lo1 = lo1; w_hi1 = hi1; w_lo2 = lo2; w_hi2 = hi2;
    cur_pair = pair;
    res = exp_result(top, def_code, none);
    exp_len = (top + 1) * (s + 1) + 1;
    @(negedge clk);
    wide_sel = wide; pair_mode = pair; settle_len = 8'(s);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wide_sel = ~wide; pair_mode = ~pair;   // captured values must hold
    check(busy && !done && !error, "R8", "busy/clear after start",
          {busy, done, error}, 3'b100);
    cyc = 0; bad_code = 0; bad_tm = 0;
    while (!done && cyc < 20000) begin
      expc = cyc / (s + 1);
      if (expc > top) expc = top;
      if (int'(trim_code) != expc && bad_code == 0) begin
        bad_code = 1;
        check(0, "R2", "code in sweep cycle", int'(trim_code), expc);
      end
      if (test_mode != !pair) bad_tm = 1;
      @(negedge clk);
      cyc++;
      start = (inject && cyc == 3);        // R9: stray start while busy
    end
    start = 1'b0;
    check(cyc == exp_len, inject ? "R9" : "R2", "run length", cyc, exp_len);
    check(bad_code == 0, "R2", "code sequence", bad_code, 0);
    check(bad_tm == 0, "R10", "test_mode during sweep", bad_tm, 0);
    check(!busy && !test_mode, "R10", "idle after done",
          {busy, test_mode}, 0);
    check(int'(trim_code) == res, none ? "R7" : (lo2 <= hi2 ? "R6" : "R5"),
          "final code", int'(trim_code), res);
    check(error == none, "R7", "error flag", error, none);
    repeat (2) @(negedge clk);
    check(done && int'(trim_code) == res, "R5", "result held idle",
          int'(trim_code), res);
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; wide_sel = 1'b0; pair_mode = 1'b0;
    settle_len = '0; cur_pair = 0;
    w_lo1 = 1; w_hi1 = 0; w_lo2 = 1; w_hi2 = 0;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check(trim_code == 6'd8 && !busy && !done && !error && !test_mode,
          "R1", "reset state", int'(trim_code), 8);
    rst_n = 1'b1;
    @(negedge clk);
    // directed corners
    run(0, 0, 1, 3, 8, 1, 0, 0);     // R3 narrow single, mid 5
    run(1, 1, 0, 10, 63, 1, 0, 0);   // R4 window to top, mid 36
    run(0, 1, 2, 15, 15, 1, 0, 0);   // single top code
    run(0, 0, 0, 0, 0, 1, 0, 0);     // single code 0
    run(0, 0, 1, 2, 4, 9, 12, 0);    // R6 second run ignored, 3
    run(1, 1, 1, 20, 25, 40, 50, 1); // R6 + R9
    run(1, 0, 0, 1, 0, 1, 0, 0);     // R7 wide none, 31
    run(0, 1, 3, 1, 0, 1, 0, 1);     // R7 narrow none, 8
    // random trials
    for (int t = 0; t < 30; t++) begin
      bit  wd, pr, inj;
      int  top, a, b, c2, d2;
      wd  = 1'($urandom % 2);
      pr  = 1'($urandom % 2);
      inj = ($urandom % 4) == 0;
      top = wd ? 63 : 15;
      a = $urandom % (top + 1);
      b = a + $urandom % (top + 1 - a);
      c2 = b + 2 + $urandom % 4;
      d2 = c2 + $urandom % 4;
      if (($urandom % 3) != 0) begin c2 = 1; d2 = 0; end
      if (($urandom % 8) == 0) begin a = 1; b = 0; c2 = 1; d2 = 0; end
      run(wd, pr, $urandom % 4, a, b, c2, d2, inj);
    end
    $display("End of test - %0d assertions evaluated, %0d failures",
             n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures",
             n_checks, n_fails);
    $finish;
  end
endmodule